// File: doc/BRIEF.md
# Trilinear Texel Address and Blend Unit

This unit turns one texture lookup request into a single filtered monochrome value. A request carries an unsigned fixed-point coordinate pair and an 8-bit fraction that selects the mix between two adjacent mip levels. The finer level is a square of `2^LOG2_DIM` texels per side. The coarser level has half that size and sits directly after it in texel memory.

For each level the unit finds the 2x2 group of texels that surrounds the sample point, clamping at the level's edge. It forms their addresses in bit-interleaved (Morton) order and puts all eight reads on a wide memory port in a single cycle, so both levels are fetched at the same time. When the data comes back after a fixed latency, each 2x2 group is blended bilinearly by the coordinate fraction. The two level results are then mixed by the level fraction, and the value is held in a result register. While a lookup is in progress the unit is busy and takes no new request.

Top module: `trilinear_sampler`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` is ignored at edges while the unit is busy, and `req_ready` is high again in the cycle where `res_valid` is high.
- R2: `rd_en` is high for exactly one cycle, the cycle right after the accepting edge. In that cycle all eight lanes of `rd_addr` carry valid addresses. Lanes 0..3 address the fine level and lanes 4..7 address the coarse level. Within a level, tap 0 is (x0,y0), tap 1 is (x1,y0), tap 2 is (x0,y1) and tap 3 is (x1,y1).
- R3: A texel address is the level base plus the Morton index of (x,y). Bit k of x goes to index bit 2k and bit k of y goes to index bit 2k+1. The fine base is 0 and the coarse base is `4^LOG2_DIM`.
- R4: With integer index i of a coordinate and level size D, x0 = min(i, D-1) and x1 = min(i+1, D-1). The same rule applies to y.
- R5: The fine level uses the request coordinate as given, with D = `2^LOG2_DIM`. The coarse level uses the coordinate shifted right by one bit, with D halved.
- R6: Each linear blend of a toward b with fraction f gives a + floor(((b-a)*f + 128) / 256), computed for FRAC_W = 8. The result always lies between a and b.
- R7: At each level, tap 0 is blended with tap 1 and tap 2 with tap 3, using the low 8 bits of the level's x coordinate. Those two results are then blended using the low 8 bits of the level's y coordinate.
- R8: The output value is the fine-level result blended toward the coarse-level result by `req_lod_frac`.
- R9: If the accepting edge is E0, `res_valid` is high for exactly one cycle, right after edge E(LAT+1). `res_data` changes only at that edge and holds its value until the next result.
- R10: During and right after reset, `req_ready` is 1 and `rd_en`, `res_valid` and `res_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_u | input | INT_W+FRAC_W | Horizontal coordinate, unsigned fixed point |
| req_v | input | INT_W+FRAC_W | Vertical coordinate, unsigned fixed point |
| req_lod_frac | input | FRAC_W | Fine-to-coarse mix fraction |
| rd_en | output | 1 | Read issue strobe for all eight lanes |
| rd_addr | output | 8*(2*LOG2_DIM+1) | Eight texel addresses, lane n at bits n*AW |
| rd_data | input | 8*TEXEL_W | Eight texels, returned LAT cycles after rd_en |
| res_valid | output | 1 | One-cycle pulse when a new result is written |
| res_data | output | TEXEL_W | Filtered result register |

## Verification
The assertions rely on the texel memory answering every `rd_en` with all eight lanes exactly LAT cycles later, and on the request fields being stable at the accepting edge. The bench keeps to this with a memory model that delays every address by a fixed LAT-stage pipeline and returns a texel value computed from that address. It changes request fields only at falling edges. Requests that arrive while the unit is busy carry deliberately different coordinates, so any wrongly accepted request would show up in the result instead of breaking an assumption.

// File: rtl/trilin_pkg.sv
package trilin_pkg;
   localparam int LEVELS = 2;
   localparam int TAPS   = 4;
   localparam int LANES  = LEVELS * TAPS;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } ctrl_state_t;
endpackage

// File: rtl/tl_lerp.sv
module tl_lerp #(
   parameter int W  = 8,
   parameter int FW = 8
) (
   input  logic [W-1:0]  a,
   input  logic [W-1:0]  b,
   input  logic [FW-1:0] f,
   output logic [W-1:0]  y
);
   localparam int PW = W + FW + 2;
   localparam logic signed [PW-1:0] RND = PW'(1) <<< (FW - 1);

   logic signed [W:0]    diff;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] sum;
   logic [W-1:0]         step;

   always_comb begin
      diff = $signed({1'b0, b}) - $signed({1'b0, a});
      prod = diff * $signed({1'b0, f});
      sum  = prod + RND;
      step = W'(sum >>> FW);
      y    = a + step;
   end

   // result never leaves the interval spanned by its endpoints
   always_comb begin
      assert_blend_bounded_R6: assert ((a <= b) ? (y >= a && y <= b) : (y <= a && y >= b))
         else $error("blend left its endpoint interval");
   end
endmodule

// File: rtl/tl_addr_gen.sv
module tl_addr_gen #(
   parameter int LVL      = 0,
   parameter int LOG2_DIM = 4,
   parameter int INT_W    = 8,
   parameter int FW       = 8,
   parameter int AW       = 9
) (
   input  logic [INT_W+FW-1:0]              u,
   input  logic [INT_W+FW-1:0]              v,
   output logic [trilin_pkg::TAPS*AW-1:0]   addr,
   output logic [FW-1:0]                    frac_x,
   output logic [FW-1:0]                    frac_y
);
   import trilin_pkg::*;

   localparam int CW      = INT_W + FW;
   localparam int LB      = LOG2_DIM - LVL;
   localparam int DIM_MAX = (1 << LB) - 1;
   localparam int BASE    = (LVL == 0) ? 0 : (1 << (2 * LOG2_DIM));
   localparam int SPAN    = 1 << (2 * LB);

   logic [CW-1:0]    su, sv;
   logic [INT_W:0]   ixa, ixb, iya, iyb;
   logic [LB-1:0]    x0, x1, y0, y1;

   always_comb begin
      su     = u >> LVL;
      sv     = v >> LVL;
      frac_x = su[FW-1:0];
      frac_y = sv[FW-1:0];
      ixa    = {1'b0, su[CW-1:FW]};
      iya    = {1'b0, sv[CW-1:FW]};
      ixb    = ixa + 1'b1;
      iyb    = iya + 1'b1;
      x0     = (ixa > (INT_W+1)'(DIM_MAX)) ? LB'(DIM_MAX) : ixa[LB-1:0];
      x1     = (ixb > (INT_W+1)'(DIM_MAX)) ? LB'(DIM_MAX) : ixb[LB-1:0];
      y0     = (iya > (INT_W+1)'(DIM_MAX)) ? LB'(DIM_MAX) : iya[LB-1:0];
      y1     = (iyb > (INT_W+1)'(DIM_MAX)) ? LB'(DIM_MAX) : iyb[LB-1:0];
   end

   for (genvar j = 0; j < TAPS; j++) begin : g_tap
      logic [LB-1:0]   tx, ty;
      logic [2*LB-1:0] mort;
      assign tx = (j % 2 == 1) ? x1 : x0;
      assign ty = (j / 2 == 1) ? y1 : y0;
      for (genvar k = 0; k < LB; k++) begin : g_bit
         assign mort[2*k]   = tx[k];
         assign mort[2*k+1] = ty[k];
      end
      assign addr[j*AW +: AW] = AW'(BASE) + AW'(mort);

      always_comb begin
         assert_addr_in_level_R4: assert (addr[j*AW +: AW] >= AW'(BASE) &&
                                          addr[j*AW +: AW] <  AW'(BASE + SPAN))
            else $error("tap address outside its level");
      end
   end
endmodule

// File: rtl/tl_ctrl.sv
module tl_ctrl #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   output logic req_ready,
   output logic accept,
   output logic rd_en,
   output logic capture
);
   import trilin_pkg::*;

   localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT + 1);

   ctrl_state_t      state;
   logic [CNT_W-1:0] cnt;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign rd_en     = (state == ST_ISSUE);
   assign capture   = (state == ST_WAIT) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE:  if (accept) state <= ST_ISSUE;
            ST_ISSUE: begin
               state <= ST_WAIT;
               cnt   <= CNT_W'(LAT - 1);
            end
            ST_WAIT: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assert_issue_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);
   assert_issue_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> $past(accept));
   assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || capture) |-> !req_ready || capture);
endmodule

// File: rtl/trilinear_sampler.sv
module trilinear_sampler #(
   parameter int LOG2_DIM = 4,
   parameter int INT_W    = 8,
   parameter int FRAC_W   = 8,
   parameter int TEXEL_W  = 8,
   parameter int LAT      = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req_valid,
   output logic                                  req_ready,
   input  logic [INT_W+FRAC_W-1:0]               req_u,
   input  logic [INT_W+FRAC_W-1:0]               req_v,
   input  logic [FRAC_W-1:0]                     req_lod_frac,
   output logic                                  rd_en,
   output logic [8*(2*LOG2_DIM+1)-1:0]           rd_addr,
   input  logic [8*TEXEL_W-1:0]                  rd_data,
   output logic                                  res_valid,
   output logic [TEXEL_W-1:0]                    res_data
);
   import trilin_pkg::*;

   localparam int CW = INT_W + FRAC_W;
   localparam int AW = 2 * LOG2_DIM + 1;

   if (LOG2_DIM < 2)      begin : g_chk_dim  $error("LOG2_DIM must be at least 2"); end
   if (INT_W < LOG2_DIM)  begin : g_chk_int  $error("INT_W must cover the fine level"); end
   if (LAT < 1)           begin : g_chk_lat  $error("LAT must be at least 1"); end
   if (FRAC_W < 1)        begin : g_chk_frac $error("FRAC_W must be positive"); end
   if (LANES != 8)        begin : g_chk_lane $error("lane count mismatch"); end

   logic              accept, capture;
   logic [CW-1:0]     u_q, v_q;
   logic [FRAC_W-1:0] lod_q;
   logic [TEXEL_W-1:0] lvl_res [LEVELS];
   logic [TEXEL_W-1:0] final_y;

   tl_ctrl #(.LAT(LAT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .accept    (accept),
      .rd_en     (rd_en),
      .capture   (capture)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         u_q   <= '0;
         v_q   <= '0;
         lod_q <= '0;
      end else if (accept) begin
         u_q   <= req_u;
         v_q   <= req_v;
         lod_q <= req_lod_frac;
      end
   end

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      logic [TAPS*AW-1:0] addr;
      logic [FRAC_W-1:0]  fx, fy;
      logic [TEXEL_W-1:0] tex [TAPS];
      logic [TEXEL_W-1:0] row0, row1;

      tl_addr_gen #(
         .LVL(l), .LOG2_DIM(LOG2_DIM), .INT_W(INT_W), .FW(FRAC_W), .AW(AW)
      ) u_addr (
         .u(u_q), .v(v_q), .addr(addr), .frac_x(fx), .frac_y(fy)
      );

      assign rd_addr[l*TAPS*AW +: TAPS*AW] = addr;

      for (genvar j = 0; j < TAPS; j++) begin : g_tex
         assign tex[j] = rd_data[(l*TAPS + j)*TEXEL_W +: TEXEL_W];
      end

      tl_lerp #(.W(TEXEL_W), .FW(FRAC_W)) u_row0 (.a(tex[0]), .b(tex[1]), .f(fx), .y(row0));
      tl_lerp #(.W(TEXEL_W), .FW(FRAC_W)) u_row1 (.a(tex[2]), .b(tex[3]), .f(fx), .y(row1));
      tl_lerp #(.W(TEXEL_W), .FW(FRAC_W)) u_col  (.a(row0),   .b(row1),   .f(fy), .y(lvl_res[l]));
   end

   tl_lerp #(.W(TEXEL_W), .FW(FRAC_W)) u_mix (
      .a(lvl_res[0]), .b(lvl_res[1]), .f(lod_q), .y(final_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= capture;
         if (capture) res_data <= final_y;
      end
   end

   assert_result_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable(res_data));
   assert_ready_with_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> req_ready);
   assert_no_issue_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !req_ready);
endmodule

// File: tb/trilinear_sampler_bench.sv
module trilinear_sampler_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LOG2_DIM   = 3;
   localparam int INT_W      = 4;
   localparam int FRAC_W     = 8;
   localparam int TEXEL_W    = 8;
   localparam int LAT        = 2;
   localparam int CW         = INT_W + FRAC_W;
   localparam int AW         = 2 * LOG2_DIM + 1;
   localparam int DIM        = 1 << LOG2_DIM;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 req_valid = 1'b0;
   logic                 req_ready;
   logic [CW-1:0]        req_u = '0;
   logic [CW-1:0]        req_v = '0;
   logic [FRAC_W-1:0]    req_lod_frac = '0;
   logic                 rd_en;
   logic [8*AW-1:0]      rd_addr;
   logic [8*TEXEL_W-1:0] rd_data;
   logic                 res_valid;
   logic [TEXEL_W-1:0]   res_data;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trilinear_sampler #(
      .LOG2_DIM(LOG2_DIM), .INT_W(INT_W), .FRAC_W(FRAC_W),
      .TEXEL_W(TEXEL_W), .LAT(LAT)
   ) u_trilinear_sampler (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_u(req_u), .req_v(req_v), .req_lod_frac(req_lod_frac),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .res_valid(res_valid), .res_data(res_data)
   );

   function automatic int texel(input int a);
      return (a * 73 + 29 + (a >> 3) * 17) & 255;
   endfunction

   // fixed-latency texel memory model
   logic [8*AW-1:0] apipe [LAT];
   always @(posedge clk) begin
      apipe[0] <= rd_addr;
      for (int i = 1; i < LAT; i++) apipe[i] <= apipe[i-1];
   end
   always @* begin
      for (int n = 0; n < 8; n++)
         rd_data[n*TEXEL_W +: TEXEL_W] = TEXEL_W'(texel(int'(apipe[LAT-1][n*AW +: AW])));
   end

   function automatic int blend(input int a, input int b, input int f);
      int t;
      t = (b - a) * f + 128;
      return a + (t >>> 8);
   endfunction

   function automatic int morton(input int x, input int y, input int bits);
      int m = 0;
      for (int k = 0; k < bits; k++) begin
         m |= ((x >> k) & 1) << (2*k);
         m |= ((y >> k) & 1) << (2*k + 1);
      end
      return m;
   endfunction

   function automatic int clampi(input int i, input int d);
      return (i > d - 1) ? d - 1 : i;
   endfunction

   // expected address of one lane (R3 R4 R5)
   function automatic int exp_addr(input int u, input int v, input int lane);
      int l, j, su, sv, d, x, y, base;
      l = lane / 4; j = lane % 4;
      su = u >> l; sv = v >> l;
      d = DIM >> l;
      x = clampi((su >> 8) + (j % 2), d);
      y = clampi((sv >> 8) + (j / 2), d);
      base = (l == 0) ? 0 : DIM * DIM;
      return base + morton(x, y, LOG2_DIM - l);
   endfunction

   // expected level result (R7)
   function automatic int exp_level(input int u, input int v, input int l);
      int t0, t1, t2, t3, fx, fy, r0, r1;
      t0 = texel(exp_addr(u, v, l*4 + 0));
      t1 = texel(exp_addr(u, v, l*4 + 1));
      t2 = texel(exp_addr(u, v, l*4 + 2));
      t3 = texel(exp_addr(u, v, l*4 + 3));
      fx = (u >> l) & 255; fy = (v >> l) & 255;
      r0 = blend(t0, t1, fx);
      r1 = blend(t2, t3, fx);
      return blend(r0, r1, fy);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_req(input int u, input int v, input int lod, input bit noise);
      int exp_res, held;
      exp_res = blend(exp_level(u, v, 0), exp_level(u, v, 1), lod);
      @(negedge clk);
      chk("R1 ready when idle", int'(req_ready), 1);
      req_u = CW'(u); req_v = CW'(v); req_lod_frac = FRAC_W'(lod); req_valid = 1'b1;
      @(negedge clk);
      chk("R2 rd_en after accept", int'(rd_en), 1);
      chk("R1 busy not ready", int'(req_ready), 0);
      for (int n = 0; n < 8; n++)
         chk("R3 R4 R5 lane address", int'(rd_addr[n*AW +: AW]), exp_addr(u, v, n));
      if (noise) begin
         req_u = CW'(~u); req_v = CW'(u ^ 12'h5a5); req_lod_frac = FRAC_W'(~lod);
      end else begin
         req_valid = 1'b0;
      end
      for (int c = 2; c <= LAT + 1; c++) begin
         @(negedge clk);
         chk("R9 no early result", int'(res_valid), 0);
         chk("R2 single issue", int'(rd_en), 0);
         if (c == LAT + 1) req_valid = 1'b0;
      end
      @(negedge clk);
      chk("R9 result pulse", int'(res_valid), 1);
      chk("R8 R6 trilinear value", int'(res_data), exp_res);
      chk("R1 ready with result", int'(req_ready), 1);
      held = int'(res_data);
      @(negedge clk);
      chk("R9 pulse ends", int'(res_valid), 0);
      chk("R9 result held", int'(res_data), held);
      chk("R1 busy request ignored", int'(rd_en), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset ready", int'(req_ready), 1);
      chk("R10 reset rd_en", int'(rd_en), 0);
      chk("R10 reset res_valid", int'(res_valid), 0);
      chk("R10 reset res_data", int'(res_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after reset ready", int'(req_ready), 1);
      chk("R10 after reset res_valid", int'(res_valid), 0);

      // directed corners: zero fractions, full fractions, far clamp
      run_req(0, 0, 0, 1'b0);
      run_req(255, 255, 255, 1'b0);
      run_req(16'h0FFF, 16'h0FFF, 128, 1'b1);
      run_req((DIM-1)*256 + 200, 3*256 + 17, 255, 1'b0);
      run_req(5*256, (DIM-1)*256 + 255, 0, 1'b1);

      // sweep every integer position, including those past the edge (R4 R5 R7)
      for (int ui = 0; ui < (1 << INT_W); ui++) begin
         for (int vi = 0; vi < (1 << INT_W); vi++) begin
            for (int k = 0; k < 3; k++) begin
               int fu, fv, lod;
               fu  = (k == 0) ? 0 : ((ui*7 + vi*13 + k*91) & 255);
               fv  = (k == 2) ? 255 : ((ui*29 + vi*3 + k*53) & 255);
               lod = (ui*31 + vi*5 + k*67) & 255;
               run_req(ui*256 + fu, vi*256 + fv, lod, (ui + vi + k) % 2 == 1);
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule